// File: doc/BRIEF.md
# DMA Standby Power-State Controller

This block sequences the power state of a DMA engine. The CPU controls it through a byte-wide command register. Writing the wake code starts the engine, and writing the sleep code asks it to stop. Reading the register returns a fixed code for the current state. The controller has four states:

- **standby**: the engine's internal clocks are gated off.
- **wake**: a single-cycle step on the way out of standby.
- **run**: the normal operating state.
- **drain**: the engine is finishing its current transfer before it parks in standby.

The controller drives the clock enable for the engine core. It also drives a start-permit line that tells the engine when a new transfer may begin.

The block holds the interrupt flags and the per-channel request mask and request enable vectors. These are updated by set strobes and register writes. When the block enters standby, it gives them a fixed set of side effects: interrupts are dropped and every channel is masked.

Top module: `dma_pwr_ctl`

## Requirements
- R1: `cmd_rdata` is 0x00 in run, 0x01 in standby, 0x02 in wake and 0x03 in drain.
- R2: While reset is low, and at the end of reset, the following hold:
  - the state is standby;
  - `clk_en` and `start_allow` are low;
  - every interrupt flag, the software start bit, `req_mask` and `req_enable` are all zero.
- R3: A command write of 0x04 in standby moves the block to wake on the next clock.
- R4: Wake lasts exactly one cycle, with `clk_en` high, and is always followed by run.
- R5: A command write of 0x08 in run moves the block to drain on the next clock.
- R6: In drain, the block stays in drain in every cycle where `xfer_busy` is high. In the first cycle where `xfer_busy` is low, the next clock moves it to standby.
- R7: On the clock that enters standby, the following happen:
  - `sw_int`, `sw_start`, `err_int` and every `hw_int` bit are cleared;
  - every `req_mask` bit is set;
  - `req_enable` keeps its value, unless an enable write arrives in that same cycle.
- R8: In standby, `clk_en` is low. All set strobes and all mask and enable writes are ignored, so every flag and vector output stays unchanged.
- R9: The following command writes leave the state unchanged:
  - 0x04 outside standby;
  - 0x08 outside run;
  - any other value.
- R10: `start_allow` is high only in run.
- R11: Outside standby, a set strobe ORs its bits into its flag, and a mask or enable write loads the vector. On the standby-entry clock, the entry clears and the mask set take priority over any coinciding set strobe or mask write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 8 | Command value written |
| cmd_rdata | output | 8 | State code read back |
| xfer_busy | input | 1 | Engine has a transfer in progress |
| clk_en | output | 1 | Clock enable for the engine core |
| start_allow | output | 1 | New transfers may start |
| sw_int_set | input | 1 | Raise software interrupt |
| sw_start_set | input | 1 | Set software start bit |
| err_int_set | input | 1 | Raise error interrupt |
| hw_int_set | input | NCH | Raise per-channel hardware interrupts |
| mask_wr | input | 1 | Load request mask vector |
| mask_wdata | input | NCH | Request mask value |
| enb_wr | input | 1 | Load request enable vector |
| enb_wdata | input | NCH | Request enable value |
| sw_int | output | 1 | Software interrupt line |
| sw_start | output | 1 | Software start bit |
| err_int | output | 1 | Error interrupt line |
| hw_int | output | NCH | Per-channel hardware interrupt lines |
| req_mask | output | NCH | Per-channel request mask |
| req_enable | output | NCH | Per-channel request enable |

## Verification
The bench builds the block with `NCH = 4`. This keeps the all-ones mask pattern and the per-channel set and clear patterns short enough to cover every bit within a few steps. With four channels, a standby entry can coincide with partial hardware-interrupt sets and with partial mask writes. It can also follow a drain that lasts either one cycle or several, and the bench walks both cases.

// File: rtl/dma_pwr_pkg.sv
package dma_pwr_pkg;

  typedef enum logic [1:0] {
    PS_STBY  = 2'd0,
    PS_WAKE  = 2'd1,
    PS_RUN   = 2'd2,
    PS_DRAIN = 2'd3
  } pwr_state_e;

  localparam int CMD_W = 8;
  localparam logic [CMD_W-1:0] CMD_WAKE  = 8'h04;
  localparam logic [CMD_W-1:0] CMD_SLEEP = 8'h08;

  // State code returned on a command register read
  function automatic logic [CMD_W-1:0] state_code(pwr_state_e s);
    case (s)
      PS_RUN:   state_code = 8'h00;
      PS_STBY:  state_code = 8'h01;
      PS_WAKE:  state_code = 8'h02;
      default:  state_code = 8'h03;
    endcase
  endfunction

  // Core clocks run in every state but standby
  function automatic logic clocks_on(pwr_state_e s);
    clocks_on = (s != PS_STBY);
  endfunction

endpackage

// File: rtl/dma_pwr_cmd.sv
module dma_pwr_cmd
  import dma_pwr_pkg::*;
(
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_wdata,
  input  pwr_state_e       state,
  output logic             wake_go,
  output logic             sleep_go
);

  logic is_wake_code;
  logic is_sleep_code;

  assign is_wake_code  = (cmd_wdata == CMD_WAKE);
  assign is_sleep_code = (cmd_wdata == CMD_SLEEP);

  // A command is only honoured in the state it belongs to
  assign wake_go  = cmd_wr && is_wake_code  && (state == PS_STBY);
  assign sleep_go = cmd_wr && is_sleep_code && (state == PS_RUN);

endmodule

// File: rtl/dma_pwr_fsm.sv
module dma_pwr_fsm
  import dma_pwr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wake_go,
  input  logic             sleep_go,
  input  logic             xfer_busy,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_wdata,
  output pwr_state_e       state,
  output logic             stby_entry,
  output logic             clk_en,
  output logic             start_allow,
  output logic [CMD_W-1:0] cmd_rdata
);

  pwr_state_e state_nx;

  assign stby_entry = (state == PS_DRAIN) && !xfer_busy;

  always_comb begin
    state_nx = state;
    case (state)
      PS_STBY:  if (wake_go)    state_nx = PS_WAKE;
      PS_WAKE:                  state_nx = PS_RUN;
      PS_RUN:   if (sleep_go)   state_nx = PS_DRAIN;
      PS_DRAIN: if (stby_entry) state_nx = PS_STBY;
      default:                  state_nx = PS_STBY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= PS_STBY;
    else        state <= state_nx;
  end

  assign clk_en      = clocks_on(state);
  assign start_allow = (state == PS_RUN);
  assign cmd_rdata   = state_code(state);

  // R3
  wake_t1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_STBY && cmd_wr && cmd_wdata == CMD_WAKE) |=> (state == PS_WAKE));

  // R4
  t1_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_WAKE) |=> (state == PS_RUN && clk_en));

  // R6
  t2_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_DRAIN && xfer_busy) |=> (state == PS_DRAIN));

  // R9
  bad_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_RUN && cmd_wr && cmd_wdata != CMD_SLEEP) |=> (state == PS_RUN));

endmodule

// File: rtl/dma_pwr_flags.sv
module dma_pwr_flags #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           upd_en,
  input  logic           stby_entry,
  input  logic           sw_int_set,
  input  logic           sw_start_set,
  input  logic           err_int_set,
  input  logic [NCH-1:0] hw_int_set,
  input  logic           mask_wr,
  input  logic [NCH-1:0] mask_wdata,
  input  logic           enb_wr,
  input  logic [NCH-1:0] enb_wdata,
  output logic           sw_int,
  output logic           sw_start,
  output logic           err_int,
  output logic [NCH-1:0] hw_int,
  output logic [NCH-1:0] req_mask,
  output logic [NCH-1:0] req_enable
);

  localparam logic [NCH-1:0] ALL_ONE = {NCH{1'b1}};

  // Single interrupt flags: entry clear beats any set
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_int   <= 1'b0;
      sw_start <= 1'b0;
      err_int  <= 1'b0;
    end else if (stby_entry) begin
      sw_int   <= 1'b0;
      sw_start <= 1'b0;
      err_int  <= 1'b0;
    end else if (upd_en) begin
      sw_int   <= sw_int   | sw_int_set;
      sw_start <= sw_start | sw_start_set;
      err_int  <= err_int  | err_int_set;
    end
  end

  // Per-channel state, one slice per channel
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hw_int[c]     <= 1'b0;
        req_mask[c]   <= 1'b0;
        req_enable[c] <= 1'b0;
      end else begin
        if (stby_entry)  hw_int[c] <= 1'b0;
        else if (upd_en) hw_int[c] <= hw_int[c] | hw_int_set[c];

        if (stby_entry)             req_mask[c] <= 1'b1;
        else if (upd_en && mask_wr) req_mask[c] <= mask_wdata[c];

        if (upd_en && enb_wr) req_enable[c] <= enb_wdata[c];
      end
    end
  end

  // R7
  stby_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stby_entry |=> (req_mask == ALL_ONE && hw_int == '0 && !sw_int && !sw_start && !err_int));

  // R8
  stby_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_en && !stby_entry) |=> ($stable(hw_int) && $stable(req_mask) && $stable(req_enable)
                                  && $stable(sw_int) && $stable(err_int)));

endmodule

// File: rtl/dma_pwr_ctl.sv
module dma_pwr_ctl
  import dma_pwr_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_wr,
  input  logic [7:0]     cmd_wdata,
  output logic [7:0]     cmd_rdata,
  input  logic           xfer_busy,
  output logic           clk_en,
  output logic           start_allow,
  input  logic           sw_int_set,
  input  logic           sw_start_set,
  input  logic           err_int_set,
  input  logic [NCH-1:0] hw_int_set,
  input  logic           mask_wr,
  input  logic [NCH-1:0] mask_wdata,
  input  logic           enb_wr,
  input  logic [NCH-1:0] enb_wdata,
  output logic           sw_int,
  output logic           sw_start,
  output logic           err_int,
  output logic [NCH-1:0] hw_int,
  output logic [NCH-1:0] req_mask,
  output logic [NCH-1:0] req_enable
);

  pwr_state_e state;
  logic       wake_go;
  logic       sleep_go;
  logic       stby_entry;

  dma_pwr_cmd u_cmd (
    .cmd_wr    (cmd_wr),
    .cmd_wdata (cmd_wdata),
    .state     (state),
    .wake_go   (wake_go),
    .sleep_go  (sleep_go)
  );

  dma_pwr_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .wake_go     (wake_go),
    .sleep_go    (sleep_go),
    .xfer_busy   (xfer_busy),
    .cmd_wr      (cmd_wr),
    .cmd_wdata   (cmd_wdata),
    .state       (state),
    .stby_entry  (stby_entry),
    .clk_en      (clk_en),
    .start_allow (start_allow),
    .cmd_rdata   (cmd_rdata)
  );

  dma_pwr_flags #(.NCH(NCH)) u_flags (
    .clk          (clk),
    .rst_n        (rst_n),
    .upd_en       (clk_en),
    .stby_entry   (stby_entry),
    .sw_int_set   (sw_int_set),
    .sw_start_set (sw_start_set),
    .err_int_set  (err_int_set),
    .hw_int_set   (hw_int_set),
    .mask_wr      (mask_wr),
    .mask_wdata   (mask_wdata),
    .enb_wr       (enb_wr),
    .enb_wdata    (enb_wdata),
    .sw_int       (sw_int),
    .sw_start     (sw_start),
    .err_int      (err_int),
    .hw_int       (hw_int),
    .req_mask     (req_mask),
    .req_enable   (req_enable)
  );

  // R10
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rdata != 8'h00) |-> !start_allow);

endmodule

// File: tb/dma_pwr_ctl_bench.sv
module dma_pwr_ctl_bench;

  localparam int NCH = 4;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           cmd_wr;
  logic [7:0]     cmd_wdata;
  logic [7:0]     cmd_rdata;
  logic           xfer_busy;
  logic           clk_en;
  logic           start_allow;
  logic           sw_int_set, sw_start_set, err_int_set;
  logic [NCH-1:0] hw_int_set;
  logic           mask_wr, enb_wr;
  logic [NCH-1:0] mask_wdata, enb_wdata;
  logic           sw_int, sw_start, err_int;
  logic [NCH-1:0] hw_int, req_mask, req_enable;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  dma_pwr_ctl #(.NCH(NCH)) u_dma_pwr_ctl (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .cmd_rdata(cmd_rdata), .xfer_busy(xfer_busy), .clk_en(clk_en),
    .start_allow(start_allow), .sw_int_set(sw_int_set), .sw_start_set(sw_start_set),
    .err_int_set(err_int_set), .hw_int_set(hw_int_set), .mask_wr(mask_wr),
    .mask_wdata(mask_wdata), .enb_wr(enb_wr), .enb_wdata(enb_wdata),
    .sw_int(sw_int), .sw_start(sw_start), .err_int(err_int), .hw_int(hw_int),
    .req_mask(req_mask), .req_enable(req_enable)
  );

  typedef struct {
    string          tag;
    logic [7:0]     rd;
    logic           en;
    logic           go;
    logic [2:0]     flg;   // {sw_int, sw_start, err_int}
    logic [NCH-1:0] hw;
    logic [NCH-1:0] msk;
    logic [NCH-1:0] enb;
  } exp_t;

  exp_t sb[$];

  // Reference state: 0 standby, 1 wake, 2 run, 3 drain
  int             m_st;
  logic [2:0]     m_flg;
  logic [NCH-1:0] m_hw, m_msk, m_enb;

  function automatic logic [7:0] ref_code(int s);
    logic [7:0] codes [4] = '{8'h01, 8'h02, 8'h00, 8'h03};
    return codes[s];
  endfunction

  function automatic string show(logic [7:0] rd, logic en, logic go, logic [2:0] f,
                                 logic [NCH-1:0] hw, logic [NCH-1:0] mk, logic [NCH-1:0] eb);
    return $sformatf("rd=%02h en=%0b go=%0b flg=%03b hw=%04b msk=%04b enb=%04b",
                     rd, en, go, f, hw, mk, eb);
  endfunction

  // Driver: one step = one clock; computes the expected post-edge outputs
  task automatic step(string tag, logic wr = 0, logic [7:0] wd = 0, logic busy = 0,
                      logic [2:0] fset = 0, logic [NCH-1:0] hset = 0,
                      logic mw = 0, logic [NCH-1:0] md = 0,
                      logic ew = 0, logic [NCH-1:0] ed = 0);
    exp_t e;
    bit   on, entry;
    int   nx;
    @(negedge clk);
    cmd_wr = wr; cmd_wdata = wd; xfer_busy = busy;
    {sw_int_set, sw_start_set, err_int_set} = fset;
    hw_int_set = hset; mask_wr = mw; mask_wdata = md; enb_wr = ew; enb_wdata = ed;
    on    = (m_st != 0);
    entry = (m_st == 3) && !busy;
    nx = m_st;
    if (m_st == 0 && wr && wd == 8'h04) nx = 1;
    else if (m_st == 1)                  nx = 2;
    else if (m_st == 2 && wr && wd == 8'h08) nx = 3;
    else if (entry)                      nx = 0;
    if (on && ew) m_enb = ed;
    if (entry) begin
      m_flg = '0; m_hw = '0; m_msk = '1;
    end else if (on) begin
      m_flg = m_flg | fset;
      m_hw  = m_hw | hset;
      if (mw) m_msk = md;
    end
    m_st = nx;
    e.tag = tag; e.rd = ref_code(m_st); e.en = (m_st != 0); e.go = (m_st == 2);
    e.flg = m_flg; e.hw = m_hw; e.msk = m_msk; e.enb = m_enb;
    sb.push_back(e);
  endtask

  // Monitor: compares each produced cycle against the queued expectation
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if ({cmd_rdata, clk_en, start_allow, sw_int, sw_start, err_int, hw_int, req_mask, req_enable}
            !== {e.rd, e.en, e.go, e.flg, e.hw, e.msk, e.enb}) begin
          fails++;
          $display("FAIL %s actual: %s expected: %s", e.tag,
                   show(cmd_rdata, clk_en, start_allow, {sw_int, sw_start, err_int},
                        hw_int, req_mask, req_enable),
                   show(e.rd, e.en, e.go, e.flg, e.hw, e.msk, e.enb));
        end
      end
    end
  end

  initial begin
    #20000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finished run");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cmd_wr = 0; cmd_wdata = 0; xfer_busy = 0;
    sw_int_set = 0; sw_start_set = 0; err_int_set = 0; hw_int_set = 0;
    mask_wr = 0; mask_wdata = 0; enb_wr = 0; enb_wdata = 0;
    m_st = 0; m_flg = 0; m_hw = 0; m_msk = 0; m_enb = 0;
    repeat (3) @(posedge clk);
    #1;
    // R2 reset state, R1 standby code
    checks++;
    if ({cmd_rdata, clk_en, start_allow, sw_int, sw_start, err_int, hw_int, req_mask, req_enable}
        !== {8'h01, 1'b0, 1'b0, 3'b000, 4'h0, 4'h0, 4'h0}) begin
      fails++;
      $display("FAIL R2 actual: %s expected: %s",
               show(cmd_rdata, clk_en, start_allow, {sw_int, sw_start, err_int},
                    hw_int, req_mask, req_enable),
               show(8'h01, 0, 0, 0, 0, 0, 0));
    end
    @(negedge clk);
    rst_n = 1;

    // R8: standby ignores sets and writes; R9: sleep code in standby ignored
    step("R8", 0, 0, 0, 3'b111, 4'hF, 1, 4'hA, 1, 4'h5);
    step("R9", 1, 8'h08);
    step("R9", 1, 8'h10);
    // R3 / R4 / R1: wake sequence
    step("R3", 1, 8'h04);
    step("R4", 0, 0, 0, 3'b010, 4'h1);
    step("R10");
    // R11: sets and writes in run; R9: wake code in run ignored
    step("R11", 1, 8'h04, 0, 3'b100, 4'h2, 1, 4'h6, 1, 4'hC);
    step("R11", 0, 0, 0, 3'b001, 4'h8, 1, 4'h3);
    step("R9", 1, 8'h0C);
    // R5: sleep with a transfer in flight; R6: hold in drain
    step("R5", 1, 8'h08, 1);
    step("R6", 0, 0, 1, 0, 4'h4);
    step("R6", 1, 8'h04, 1);
    step("R10", 1, 8'h08, 1, 0, 0, 0, 0, 1, 4'h9);
    // R7 / R11: entry coinciding with sets and a mask write
    step("R7", 0, 0, 0, 3'b111, 4'hF, 1, 4'h0);
    step("R8", 0, 0, 0, 3'b101, 4'h3, 1, 4'h2, 1, 4'h1);
    step("R1");
    // Second wake, immediate drain of one cycle
    step("R3", 1, 8'h04);
    step("R4", 1, 8'h08);
    step("R11", 0, 0, 0, 3'b010, 4'h5, 1, 4'h0);
    step("R5", 1, 8'h08, 0);
    step("R7", 0, 0, 0, 0, 0, 0, 0, 1, 4'h7);
    step("R8", 1, 8'h00, 0, 3'b111, 4'hF);
    step("R1");
    step("R1");
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule